// File: doc/BRIEF.md
# PLL Output Divider GO Controller

This block drives a bank of clock dividers from one PLL output clock. Each divider has a register that holds an enable flag and a ratio field. Software stages new values there, marks which dividers must restart in phase and which have a new ratio, and then issues a GO command. The new ratios take effect together in one synchronized step. A busy status bit stays set while that step runs, and software polls it.

A GO is handled in three stages. First, every divider in the selected set (align mask OR change mask) finishes its current period and parks with its output held low. Dividers outside the set keep running. Once all selected dividers are parked, they load their staged values on the same input clock edge (only the ones whose change bit is set take the new ratio) and restart their counters together. The change bits of the selected dividers then clear. A disabled divider, or one with ratio zero, passes the input clock straight through. Its output is gated by a flop clocked on the falling edge, so parking and restarting such a lane does not produce a runt pulse.

The bus is a single-cycle write strobe with a byte address. Read data is combinational from the address. Every part of the block runs on the PLL clock.

Top module: `pll_div_go_ctrl`

## Requirements
- R1: After reset, all divider registers, the align mask, the change mask and the status register read 0. Every output follows the input clock: it is high just after a rising edge and low just after a falling edge.
- R2: Divider i (0..7) sits at byte offset 0x18, 0x1C, 0x20, 0x60, 0x64, 0x68, 0x6C or 0x70 respectively. Bit 15 holds the enable flag and bits RATIO_W-1:0 hold the ratio (RATIO_W = 9 by default). A read returns the staged value, and every other bit reads 0.
- R3: An enabled divider with ratio r > 0 divides by N = r+1. From a restart, its output is high for floor(N/2) input cycles and then low for the rest of the period. If the divider is disabled or r = 0, the output passes the input clock.
- R4: A write to a divider register changes no output until a GO is issued.
- R5: Writing a value with bit 0 set to offset 0x38 issues a GO. The GO loads staged values only into dividers whose bit i is set in the change mask (offset 0x44). Any other divider keeps its previous ratio.
- R6: All dividers whose bit is set in the align mask (offset 0x40) or the change mask restart on the same input edge. Each of these outputs begins its period (high, for a divided lane) on that edge.
- R7: Bit 0 of offset 0x3C reads 1 from the edge that accepts the GO until the restart edge, and reads 0 from then on. On the restart edge, the change bits of the restarted dividers clear.
- R8: A GO written while bit 0 of 0x3C is 1 is ignored. Once busy clears, it stays clear.
- R9: A selected divider parks only at the end of a period, where its output is already low. While parked, its output stays low. A divider that is not selected keeps toggling throughout a GO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock that feeds every divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, taken on the rising edge |
| bus_addr | input | 8 | Byte offset used for both write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| div_clk | output | NUM_DIV | Divided clock outputs, one per divider |

## Verification
If a counter goes wrong, the high/low pattern on that divider's output shifts within a single output period. Patterns are therefore compared sample by sample, starting at the restart edge that the status bit marks. A lane that parks or restarts incorrectly shows up one of two ways: an output that should be free-running stops toggling during a GO, or aligned lanes no longer rise on the same cycle. If the sequencer's state is wrong, the busy bit rises or clears on the wrong cycle, or it re-asserts after a GO that should have been ignored. The change mask readback shows this within one cycle of completion.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int EN_BIT = 15;

  localparam logic [ADDR_W-1:0] OFS_CMD   = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_ALIGN = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_CHG   = 8'h44;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DRAIN = 2'd1,
    SEQ_LOAD  = 2'd2
  } seq_state_e;

  // {hit, index} for a divider register offset
  function automatic logic [3:0] slot_of(input logic [ADDR_W-1:0] a);
    logic [3:0] s;
    case (a)
      8'h18:   s = 4'b1000;
      8'h1C:   s = 4'b1001;
      8'h20:   s = 4'b1010;
      8'h60:   s = 4'b1011;
      8'h64:   s = 4'b1100;
      8'h68:   s = 4'b1101;
      8'h6C:   s = 4'b1110;
      8'h70:   s = 4'b1111;
      default: s = 4'b0000;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pll_div_regs.sv
module pll_div_regs
  import pll_div_pkg::*;
#(
  parameter int NUM_DIV = 8,
  parameter int RATIO_W = 9
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [DATA_W-1:0]               bus_rdata,
  input  logic                            busy,
  input  logic                            chg_clr,
  input  logic [NUM_DIV-1:0]              clr_mask,
  output logic [NUM_DIV-1:0]              shd_en,
  output logic [NUM_DIV-1:0][RATIO_W-1:0] shd_ratio,
  output logic [NUM_DIV-1:0]              align_mask,
  output logic [NUM_DIV-1:0]              chg_mask,
  output logic                            go_wr
);

  logic [3:0] slot;
  logic       slot_hit;

  assign slot     = slot_of(bus_addr);
  assign slot_hit = slot[3] && (int'(slot[2:0]) < NUM_DIV);
  assign go_wr    = bus_wr && (bus_addr == OFS_CMD) && bus_wdata[0];

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_en[i]    <= 1'b0;
        shd_ratio[i] <= '0;
      end else if (bus_wr && slot_hit && (slot[2:0] == 3'(i))) begin
        shd_en[i]    <= bus_wdata[EN_BIT];
        shd_ratio[i] <= bus_wdata[RATIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_mask <= '0;
      chg_mask   <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_ALIGN) align_mask <= bus_wdata[NUM_DIV-1:0];
      if (bus_wr && bus_addr == OFS_CHG)
        chg_mask <= bus_wdata[NUM_DIV-1:0];
      else if (chg_clr)
        chg_mask <= chg_mask & ~clr_mask;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (slot_hit && slot[2:0] == 3'(i)) begin
        bus_rdata[EN_BIT]        = shd_en[i];
        bus_rdata[RATIO_W-1:0]   = shd_ratio[i];
      end
    end
    if (bus_addr == OFS_ALIGN) bus_rdata[NUM_DIV-1:0] = align_mask;
    if (bus_addr == OFS_CHG)   bus_rdata[NUM_DIV-1:0] = chg_mask;
    if (bus_addr == OFS_STAT)  bus_rdata[0]           = busy;
  end

endmodule

// File: rtl/pll_go_seq.sv
module pll_go_seq
  import pll_div_pkg::*;
#(
  parameter int NUM_DIV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_wr,
  input  logic [NUM_DIV-1:0] align_mask,
  input  logic [NUM_DIV-1:0] chg_mask,
  input  logic [NUM_DIV-1:0] parked,
  output logic [NUM_DIV-1:0] park_req,
  output logic [NUM_DIV-1:0] restart,
  output logic [NUM_DIV-1:0] load,
  output logic               busy,
  output logic               chg_clr,
  output logic [NUM_DIV-1:0] clr_mask
);

  seq_state_e        state;
  logic [NUM_DIV-1:0] sel_q;
  logic               all_parked;

  assign all_parked = &(parked | ~sel_q);
  assign busy       = (state != SEQ_IDLE);
  assign park_req   = (state == SEQ_DRAIN) ? sel_q : '0;
  assign restart    = (state == SEQ_LOAD)  ? sel_q : '0;
  assign load       = restart & chg_mask;
  assign chg_clr    = (state == SEQ_LOAD);
  assign clr_mask   = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      sel_q <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (go_wr) begin
          sel_q <= align_mask | chg_mask;
          state <= SEQ_DRAIN;
        end
        SEQ_DRAIN: if (all_parked) state <= SEQ_LOAD;
        default:   state <= SEQ_IDLE;
      endcase
    end
  end

  // R8: a GO arriving while busy leaves the captured selection untouched
  a_r8_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_wr) |=> $stable(sel_q));

  // R7: the load step always ends the busy window on the next edge
  a_r7_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_LOAD) |=> !busy);

  // R6: restart is only issued once every selected lane reports parked
  a_r6_restart_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (|restart) |-> ((parked & sel_q) == sel_q));

endmodule

// File: rtl/pll_div_lane.sv
module pll_div_lane #(
  parameter int RATIO_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               park_req,
  input  logic               restart,
  input  logic               load,
  input  logic               new_en,
  input  logic [RATIO_W-1:0] new_ratio,
  output logic               parked,
  output logic               clk_o
);

  localparam int CW = RATIO_W + 1;

  function automatic logic [CW-1:0] high_len(input logic [RATIO_W-1:0] last);
    return ({1'b0, last} + CW'(1)) >> 1;
  endfunction

  logic [RATIO_W-1:0] last_q;
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] cnt_nx;
  logic [RATIO_W-1:0] next_last;
  logic               out_q;
  logic               park_q;
  logic               gate_q;
  logic               bypass;
  logic               period_end;

  assign next_last  = load ? (new_en ? new_ratio : '0) : last_q;
  assign bypass     = (last_q == '0);
  assign period_end = (cnt_q == last_q);
  assign cnt_nx     = period_end ? '0 : cnt_q + 1'b1;
  assign parked     = park_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b0;
      park_q <= 1'b0;
    end else if (restart) begin
      last_q <= next_last;
      cnt_q  <= '0;
      park_q <= 1'b0;
      out_q  <= (next_last != '0);
    end else if (park_q) begin
      cnt_q  <= '0;
    end else if (park_req && period_end) begin
      park_q <= 1'b1;
      out_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_nx;
      out_q  <= ({1'b0, cnt_nx} < high_len(last_q));
    end
  end

  // pass-through gate, updated while the input clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= !park_q;
  end

  assign clk_o = bypass ? (clk & gate_q) : out_q;

  // R9: a parked lane holds its divided output low
  a_r9_park_low: assert property (@(posedge clk) disable iff (!rst_n)
    park_q |-> !out_q);

  // R9: parking starts only where the previous output was low
  a_r9_enter_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(park_q) |-> $past(!out_q));

  // R3: the counter never passes the period end
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_q);

  // R6: a restart leaves the lane at the start of its period
  a_r6_restart_start: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && !park_q));

endmodule

// File: rtl/pll_div_go_ctrl.sv
module pll_div_go_ctrl
  import pll_div_pkg::*;
#(
  parameter int NUM_DIV = 8,
  parameter int RATIO_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_DIV-1:0] div_clk
);

  logic [NUM_DIV-1:0]              shd_en;
  logic [NUM_DIV-1:0][RATIO_W-1:0] shd_ratio;
  logic [NUM_DIV-1:0]              align_mask;
  logic [NUM_DIV-1:0]              chg_mask;
  logic                            go_wr;
  logic                            busy;
  logic                            chg_clr;
  logic [NUM_DIV-1:0]              clr_mask;
  logic [NUM_DIV-1:0]              park_req;
  logic [NUM_DIV-1:0]              restart;
  logic [NUM_DIV-1:0]              load;
  logic [NUM_DIV-1:0]              parked;

  pll_div_regs #(.NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .chg_clr    (chg_clr),
    .clr_mask   (clr_mask),
    .shd_en     (shd_en),
    .shd_ratio  (shd_ratio),
    .align_mask (align_mask),
    .chg_mask   (chg_mask),
    .go_wr      (go_wr)
  );

  pll_go_seq #(.NUM_DIV(NUM_DIV)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_wr      (go_wr),
    .align_mask (align_mask),
    .chg_mask   (chg_mask),
    .parked     (parked),
    .park_req   (park_req),
    .restart    (restart),
    .load       (load),
    .busy       (busy),
    .chg_clr    (chg_clr),
    .clr_mask   (clr_mask)
  );

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_lane
    pll_div_lane #(.RATIO_W(RATIO_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .park_req  (park_req[i]),
      .restart   (restart[i]),
      .load      (load[i]),
      .new_en    (shd_en[i]),
      .new_ratio (shd_ratio[i]),
      .parked    (parked[i]),
      .clk_o     (div_clk[i])
    );
  end

  // R7: change bits of restarted lanes are clear after the restart edge
  a_r7_chg_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_clr && !(bus_wr && bus_addr == OFS_CHG)) |=> ((chg_mask & $past(clr_mask)) == '0));

endmodule

// File: tb/pll_div_go_ctrl_bench.sv
module pll_div_go_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0;
  logic [7:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NUM-1:0] div_clk;

  int total = 0;
  int bad = 0;
  logic [NUM-1:0] samp [0:63];

  localparam logic [7:0] A_CMD = 8'h38, A_STAT = 8'h3C, A_ALIGN = 8'h40, A_CHG = 8'h44;
  logic [7:0] dofs [0:7];

  pll_div_go_ctrl #(.NUM_DIV(NUM), .RATIO_W(9)) u_pll_div_go_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div_clk(div_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic exp_bit(input int n, input bit sel, input int i);
    if (n == 1) return !(sel && i == 0);
    return (i % n) < (n / 2);
  endfunction

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      samp[i] = div_clk;
      @(posedge clk); #1;
    end
  endtask

  task automatic check_lane(input int lane, input int n, input bit sel, input int cnt, input string req);
    for (int i = 0; i < cnt; i++)
      chk(samp[i][lane] == exp_bit(n, sel, i), req, int'(samp[i][lane]), int'(exp_bit(n, sel, i)));
  endtask

  task automatic count_high(input int lane, input int cnt, input int exp, input string req);
    int h = 0;
    for (int i = 0; i < cnt; i++) h += int'(samp[i][lane]);
    chk(h == exp, req, h, exp);
  endtask

  // issue GO, confirm busy, then wait until the restart edge (sample point index 0)
  task automatic go_sync(input string req);
    logic [31:0] d;
    int guard = 0;
    wr(A_CMD, 32'h1);
    rd(A_STAT, d);
    chk(d[0] == 1'b1, req, int'(d[0]), 1);
    @(posedge clk); #1;
    rd(A_STAT, d);
    while (d[0] && guard < 2000) begin
      @(posedge clk); #1;
      rd(A_STAT, d);
      guard++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < NUM; i++) begin
      rd(dofs[i], d);
      chk(d == 0, "R1 divider reg", int'(d), 0);
    end
    rd(A_ALIGN, d); chk(d == 0, "R1 align", int'(d), 0);
    rd(A_CHG, d);   chk(d == 0, "R1 change", int'(d), 0);
    rd(A_STAT, d);  chk(d == 0, "R1 status", int'(d), 0);
    @(posedge clk); #1;
    chk(div_clk == '1, "R1 out high", int'(div_clk), 255);
    @(negedge clk); #1;
    chk(div_clk == '0, "R1 out low", int'(div_clk), 0);
  endtask

  task automatic t_layout;
    logic [31:0] d;
    wr(dofs[3], 32'hFFFF_FFFF);
    rd(dofs[3], d); chk(d == 32'h81FF, "R2 all ones", int'(d), 'h81FF);
    wr(dofs[0], 32'h0000_7E05);
    rd(dofs[0], d); chk(d == 32'h0005, "R2 field mask", int'(d), 5);
    wr(dofs[7], 32'h0000_8010);
    rd(dofs[7], d); chk(d == 32'h8010, "R2 last offset", int'(d), 'h8010);
    rd(dofs[6], d); chk(d == 0, "R2 neighbour", int'(d), 0);
    wr(dofs[7], 32'h0);
  endtask

  task automatic t_shadow;
    wr(dofs[0], 32'h8003);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk(div_clk == '1, "R4 no effect before GO", int'(div_clk), 255);
    end
  endtask

  task automatic t_go_change;
    logic [31:0] d;
    wr(dofs[1], 32'h8002);
    wr(dofs[2], 32'h8001);
    wr(dofs[4], 32'h8000);
    wr(A_CHG, 32'h17);
    go_sync("R7 busy set");
    capture(12);
    check_lane(0, 4, 1, 12, "R3 R6 lane0 div4");
    check_lane(1, 3, 1, 12, "R3 R6 lane1 div3");
    check_lane(2, 2, 1, 12, "R3 R6 lane2 div2");
    check_lane(3, 1, 0, 12, "R5 lane3 unchanged");
    check_lane(4, 1, 1, 12, "R3 lane4 ratio0 passthrough");
    check_lane(6, 1, 0, 12, "R5 lane6 unselected");
    rd(A_CHG, d); chk(d == 0, "R7 change cleared", int'(d), 0);
  endtask

  task automatic t_align_only;
    logic [31:0] d;
    wr(dofs[2], 32'h8004);
    wr(A_ALIGN, 32'h03);
    go_sync("R7 busy set align");
    capture(24);
    check_lane(0, 4, 1, 24, "R6 lane0 aligned");
    check_lane(1, 3, 1, 24, "R6 lane1 aligned");
    count_high(2, 24, 12, "R5 lane2 keeps div2");
    rd(dofs[2], d); chk(d == 32'h8004, "R4 shadow kept", int'(d), 'h8004);
    wr(A_ALIGN, 32'h0);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] d;
    int guard = 0;
    int n = 0;
    logic l5_prev = 1'b1, l5_last = 1'b1;
    // put lane 5 on a long period
    wr(dofs[5], 32'h8027);
    wr(A_CHG, 32'h20);
    go_sync("R7 busy set slow");
    capture(40);
    count_high(5, 40, 20, "R3 lane5 div40");
    // second GO: lane 5 must drain for a whole period
    wr(A_ALIGN, 32'h20);
    wr(A_CMD, 32'h1);
    rd(A_STAT, d); chk(d[0] == 1'b1, "R7 busy slow drain", int'(d[0]), 1);
    wr(A_CMD, 32'h1);  // ignored, R8
    @(posedge clk); #1;
    rd(A_STAT, d);
    while (d[0] && guard < 2000) begin
      if (n < 64) samp[n] = div_clk;
      n++;
      l5_prev = l5_last; l5_last = div_clk[5];
      @(posedge clk); #1;
      rd(A_STAT, d);
      guard++;
    end
    chk(l5_prev == 1'b0 && l5_last == 1'b0, "R9 parked lane low", int'({l5_prev, l5_last}), 0);
    if (n >= 20) count_high(2, 20, 10, "R9 unselected lane toggles");
    else chk(0, "R9 drain too short", n, 20);
    capture(8);
    check_lane(5, 40, 1, 8, "R6 lane5 restart");
    for (int i = 0; i < 6; i++) begin
      rd(A_STAT, d);
      chk(d[0] == 1'b0, "R8 no second GO", int'(d[0]), 0);
      @(posedge clk); #1;
    end
    wr(A_ALIGN, 32'h0);
  endtask

  initial begin
    dofs[0] = 8'h18; dofs[1] = 8'h1C; dofs[2] = 8'h20; dofs[3] = 8'h60;
    dofs[4] = 8'h64; dofs[5] = 8'h68; dofs[6] = 8'h6C; dofs[7] = 8'h70;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_layout();
    t_shadow();
    t_go_change();
    t_align_only();
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule